// File: doc/BRIEF.md
# Embedded-Sync Video Stream Parser

This block takes a bit-parallel digital video stream of 8- or 10-bit samples. The stream carries its horizontal, vertical and field timing as in-band code words rather than on separate sync wires. A timing code is a preamble of three reserved words followed by a status word that holds the H, V and F flags. The parser finds these codes and tracks where each line starts and ends. It passes active picture samples downstream with a valid strobe. It also flags where a line starts and ends, which field is current, and whether the stream is in vertical blanking. Row, partial-frame and frame completion pulses are provided for a transfer engine that consumes the pixels.

The line length and the frame length are set on input ports, so the same block handles the 720-sample active lines of both broadcast systems (486 or 576 active lines) and smaller formats such as CIF. A sample is only taken when `din_en` is high. An end-of-active code that arrives too early marks the stream as out of step. The parser then hunts for the next start-of-active code before it emits anything further.

Line tracking is a four-state machine:
- `ST_HUNT` is the reset state and the state entered after a loss of sync. A start code leads to `ST_ACTIVE` when V=0 and to `ST_VBLANK` when V=1. End codes are ignored here.
- `ST_ACTIVE` counts samples. An end code with a full line leads to `ST_HBLANK`. An end code with a short line leads to `ST_HUNT`. A start code restarts the line through the same V rule.
- `ST_HBLANK` waits. A start code leaves it through the V rule.
- `ST_VBLANK` emits nothing. An end code leads to `ST_HBLANK`, and a start code leaves through the V rule.

Top module: `emb_sync_parser`

## Requirements
- R1: A timing code is recognised on an accepted word whose compared byte has bit 7 set, when the three accepted words before it had compared bytes 0xFF, 0x00, 0x00 in that order. The compared byte is `din[7:0]` when `wide_mode`=0 and `din[9:2]` when `wide_mode`=1. Bit 6 of that byte is F, bit 5 is V and bit 4 is H. Bits 3..0 are ignored. H=0 marks start of active video and H=1 marks end of active video. Any other pattern, including a status byte with bit 7 clear, is not a code.
- R2: After a start code with V=0, the first `cfg_active_samples` accepted words that are not code words appear on `pix_data` with `pix_valid` high, one clock after they are presented. The data is zero-extended from `din[7:0]` in 8-bit mode and taken whole in 10-bit mode. Further words on that line are dropped.
- R3: `pix_valid` is never high for words between an end code and the next start code. It is never high on a line whose start code had V=1, and never before the first start code.
- R4: `line_start` is high together with the first pixel of a line, and `line_end` is high together with pixel number `cfg_active_samples`.
- R5: `line_done` pulses for one clock, one clock after the status word of an end code, when at least `cfg_active_samples` pixels plus the three preamble words were accepted since the start code.
- R6: `field_id` and `vblank` hold the F and V flags of the most recent code of either kind, updated one clock after its status word.
- R7: `frame_start` pulses for one clock, one clock after a start code with V=1 and F=0 when the previous start code had F=1.
- R8: An active line counter is cleared by each frame start and advances on each `line_done`. `frame_done` pulses together with the `line_done` of active line number `cfg_frame_lines`.
- R9: `partial_done` pulses together with the `line_done` of active line number `cfg_partial_lines`. A value of 0 disables it.
- R10: An end code with too few accepted words (see R5) sets `sync_lost` one clock later, gives no `line_done`, and returns the parser to hunting. While hunting, no pixels or line pulses appear. The next start code clears `sync_lost`.
- R11: Reset clears every output to 0 and leaves the parser hunting, so words and end codes before the first start code have no effect.
- R12: A word presented with `din_en`=0 is ignored. It neither advances code detection nor counts as a pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1 selects 10-bit samples, 0 selects 8-bit |
| din_en | input | 1 | Qualifies `din` for this clock |
| din | input | DATA_W | Video sample or code word |
| cfg_active_samples | input | PIX_W | Active samples per line |
| cfg_frame_lines | input | LINE_W | Active lines per frame |
| cfg_partial_lines | input | LINE_W | Line count for the partial-frame pulse, 0 = off |
| pix_valid | output | 1 | Active pixel strobe |
| pix_data | output | DATA_W | Active pixel value |
| line_start | output | 1 | First pixel of a line |
| line_end | output | 1 | Last counted pixel of a line |
| field_id | output | 1 | F flag of the latest code |
| vblank | output | 1 | V flag of the latest code |
| frame_start | output | 1 | Frame start pulse |
| line_done | output | 1 | Row completion pulse |
| partial_done | output | 1 | Partial-frame completion pulse |
| frame_done | output | 1 | Frame completion pulse |
| sync_lost | output | 1 | Short line seen, waiting for a start code |

## Verification
The embedded properties check, on every cycle, several relations between outputs and state:
- no pixel follows a clock spent outside `ST_ACTIVE`;
- `line_start` and `line_end` only occur with a pixel;
- completion pulses only coincide with `line_done`;
- a rising `sync_lost` always lands in `ST_HUNT`;
- `frame_start` only occurs with V=1 and F=0 reported.

Three things depend on the stream as a whole, so only the bench scenarios can show them:
- that codes are found, and near-miss patterns rejected, in both sample widths;
- that pixel values and their one-clock latency are exact, and that surplus samples are dropped;
- that frame and partial-frame counts come out right as the line length and partial setting are swept, that gaps in `din_en` have no effect, and that recovery after a short line works.

// File: rtl/esp_pkg.sv
package esp_pkg;

    // Number of reserved words ahead of the status word of a timing code.
    localparam int PRE_WORDS = 3;
    localparam logic [7:0] PRE_LEAD = 8'hFF;
    localparam logic [7:0] PRE_FILL = 8'h00;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_HBLANK,
        ST_ACTIVE,
        ST_VBLANK
    } line_state_e;

    typedef struct packed {
        logic hit;
        logic f;
        logic v;
        logic h;
    } trs_info_t;

endpackage

// File: rtl/esp_trs_detect.sv
module esp_trs_detect
    import esp_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic              din_en,
    input  logic [DATA_W-1:0] din,
    output trs_info_t         trs
);

    logic [7:0] byte_now;
    logic [7:0] hist_q [PRE_WORDS];
    logic       pre_ok;

    // Compare on the top eight bits of a wide sample, or the low byte otherwise.
    assign byte_now = wide_mode ? din[DATA_W-1 -: 8] : din[7:0];

    // History of accepted bytes, newest in slot 0.
    generate
        for (genvar gi = 0; gi < PRE_WORDS; gi++) begin : g_hist
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hist_q[gi] <= 8'h01;
                end else if (din_en) begin
                    if (gi == 0) begin
                        hist_q[gi] <= byte_now;
                    end else begin
                        hist_q[gi] <= hist_q[gi-1];
                    end
                end
            end
        end
    endgenerate

    always_comb begin
        pre_ok = (hist_q[PRE_WORDS-1] == PRE_LEAD);
        for (int i = 0; i < PRE_WORDS - 1; i++) begin
            pre_ok = pre_ok && (hist_q[i] == PRE_FILL);
        end
    end

    always_comb begin
        trs.hit = din_en && pre_ok && byte_now[7];
        trs.f   = byte_now[6];
        trs.v   = byte_now[5];
        trs.h   = byte_now[4];
    end

endmodule

// File: rtl/esp_line_fsm.sv
module esp_line_fsm
    import esp_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int PIX_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic              din_en,
    input  logic [DATA_W-1:0] din,
    input  logic              sav_hit,
    input  logic              eav_hit,
    input  logic              code_v,
    input  logic [PIX_W-1:0]  cfg_active,
    output logic              pix_valid,
    output logic [DATA_W-1:0] pix_data,
    output logic              line_start,
    output logic              line_end,
    output logic              line_done,
    output logic              sync_lost,
    output logic              line_ok
);

    localparam int CW = PIX_W + 1;
    localparam logic [CW-1:0] CNT_MAX = '1;
    localparam logic [CW-1:0] PRE_LEN = CW'(PRE_WORDS);

    line_state_e state_q, state_d, sav_target;
    logic [CW-1:0] cnt_q, n_c, need_c;
    logic accept_word, emit, short_line, eav_bad, any_code;

    assign n_c        = {1'b0, cfg_active};
    assign need_c     = n_c + PRE_LEN;
    assign any_code   = sav_hit || eav_hit;
    assign sav_target = code_v ? ST_VBLANK : ST_ACTIVE;

    assign accept_word = din_en && !any_code && (state_q == ST_ACTIVE);
    assign emit        = accept_word && (cnt_q < n_c);
    assign short_line  = cnt_q < need_c;
    assign line_ok     = (state_q == ST_ACTIVE) && eav_hit && !short_line;
    assign eav_bad     = (state_q == ST_ACTIVE) && eav_hit && short_line;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT: begin
                if (sav_hit) state_d = sav_target;
            end
            ST_HBLANK: begin
                if (sav_hit) state_d = sav_target;
            end
            ST_ACTIVE: begin
                if (eav_hit)      state_d = short_line ? ST_HUNT : ST_HBLANK;
                else if (sav_hit) state_d = sav_target;
            end
            ST_VBLANK: begin
                if (eav_hit)      state_d = ST_HBLANK;
                else if (sav_hit) state_d = sav_target;
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // State register and sample counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (sav_hit) begin
                cnt_q <= '0;
            end else if (accept_word && cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid  <= 1'b0;
            pix_data   <= '0;
            line_start <= 1'b0;
            line_end   <= 1'b0;
            line_done  <= 1'b0;
            sync_lost  <= 1'b0;
        end else begin
            pix_valid  <= emit;
            if (emit) begin
                pix_data <= wide_mode ? din : DATA_W'(din[7:0]);
            end
            line_start <= emit && (cnt_q == '0);
            line_end   <= emit && ((cnt_q + 1'b1) == n_c);
            line_done  <= line_ok;
            if (eav_bad) begin
                sync_lost <= 1'b1;
            end else if (sav_hit) begin
                sync_lost <= 1'b0;
            end
        end
    end

    // R3
    no_pix_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ACTIVE) |=> !pix_valid);

    // R4
    line_start_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> pix_valid);

    // R4
    line_end_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |-> pix_valid);

    // R10
    lost_enters_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_lost) |-> (state_q == ST_HUNT));

    // R5
    done_not_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> !sync_lost);

endmodule

// File: rtl/esp_frame_track.sv
module esp_frame_track
    import esp_pkg::*;
#(
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  trs_info_t         trs,
    input  logic              line_ok,
    input  logic              line_done,
    input  logic [LINE_W-1:0] cfg_frame_lines,
    input  logic [LINE_W-1:0] cfg_partial_lines,
    output logic              field_id,
    output logic              vblank,
    output logic              frame_start,
    output logic              frame_done,
    output logic              partial_done
);

    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    logic              last_f_q;
    logic [LINE_W-1:0] line_cnt_q;
    logic [LINE_W:0]   line_nxt;
    logic              sav, fs_c;

    assign sav      = trs.hit && !trs.h;
    assign fs_c     = sav && trs.v && !trs.f && last_f_q;
    assign line_nxt = {1'b0, line_cnt_q} + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_id     <= 1'b0;
            vblank       <= 1'b0;
            last_f_q     <= 1'b0;
            line_cnt_q   <= '0;
            frame_start  <= 1'b0;
            frame_done   <= 1'b0;
            partial_done <= 1'b0;
        end else begin
            if (trs.hit) begin
                field_id <= trs.f;
                vblank   <= trs.v;
            end
            if (sav) begin
                last_f_q <= trs.f;
            end
            frame_start <= fs_c;
            if (fs_c) begin
                line_cnt_q <= '0;
            end else if (line_ok && line_cnt_q != LINE_MAX) begin
                line_cnt_q <= line_cnt_q + 1'b1;
            end
            frame_done   <= line_ok && (line_nxt == {1'b0, cfg_frame_lines});
            partial_done <= line_ok && (cfg_partial_lines != '0)
                            && (line_nxt == {1'b0, cfg_partial_lines});
        end
    end

    // R8
    frame_done_on_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> line_done);

    // R9
    partial_on_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        partial_done |-> line_done);

    // R7
    fs_in_vblank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (vblank && !field_id));

endmodule

// File: rtl/emb_sync_parser.sv
module emb_sync_parser
    import esp_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int PIX_W  = 11,
    parameter int LINE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_mode,
    input  logic              din_en,
    input  logic [DATA_W-1:0] din,
    input  logic [PIX_W-1:0]  cfg_active_samples,
    input  logic [LINE_W-1:0] cfg_frame_lines,
    input  logic [LINE_W-1:0] cfg_partial_lines,
    output logic              pix_valid,
    output logic [DATA_W-1:0] pix_data,
    output logic              line_start,
    output logic              line_end,
    output logic              field_id,
    output logic              vblank,
    output logic              frame_start,
    output logic              line_done,
    output logic              partial_done,
    output logic              frame_done,
    output logic              sync_lost
);

    trs_info_t trs;
    logic      line_ok;

    esp_trs_detect #(.DATA_W(DATA_W)) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide_mode (wide_mode),
        .din_en    (din_en),
        .din       (din),
        .trs       (trs)
    );

    esp_line_fsm #(.DATA_W(DATA_W), .PIX_W(PIX_W)) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .wide_mode  (wide_mode),
        .din_en     (din_en),
        .din        (din),
        .sav_hit    (trs.hit && !trs.h),
        .eav_hit    (trs.hit && trs.h),
        .code_v     (trs.v),
        .cfg_active (cfg_active_samples),
        .pix_valid  (pix_valid),
        .pix_data   (pix_data),
        .line_start (line_start),
        .line_end   (line_end),
        .line_done  (line_done),
        .sync_lost  (sync_lost),
        .line_ok    (line_ok)
    );

    esp_frame_track #(.LINE_W(LINE_W)) u_frame (
        .clk               (clk),
        .rst_n             (rst_n),
        .trs               (trs),
        .line_ok           (line_ok),
        .line_done         (line_done),
        .cfg_frame_lines   (cfg_frame_lines),
        .cfg_partial_lines (cfg_partial_lines),
        .field_id          (field_id),
        .vblank            (vblank),
        .frame_start       (frame_start),
        .frame_done        (frame_done),
        .partial_done      (partial_done)
    );

endmodule

// File: tb/test_emb_sync_parser.sv
`timescale 1ns/1ps
module test_emb_sync_parser;

    localparam int DW = 10;
    localparam int PW = 11;
    localparam int LW = 10;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          wide_mode = 1'b0;
    logic          din_en = 1'b0;
    logic [DW-1:0] din = '0;
    logic [PW-1:0] cfg_active_samples = PW'(4);
    logic [LW-1:0] cfg_frame_lines = LW'(3);
    logic [LW-1:0] cfg_partial_lines = LW'(2);
    logic          pix_valid, line_start, line_end, field_id, vblank;
    logic          frame_start, line_done, partial_done, frame_done, sync_lost;
    logic [DW-1:0] pix_data;

    emb_sync_parser i_emb_sync_parser (
        .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .din_en(din_en), .din(din),
        .cfg_active_samples(cfg_active_samples), .cfg_frame_lines(cfg_frame_lines),
        .cfg_partial_lines(cfg_partial_lines), .pix_valid(pix_valid), .pix_data(pix_data),
        .line_start(line_start), .line_end(line_end), .field_id(field_id), .vblank(vblank),
        .frame_start(frame_start), .line_done(line_done), .partial_done(partial_done),
        .frame_done(frame_done), .sync_lost(sync_lost)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [DW-1:0] q_dat [$];
    int            q_cyc [$];
    int c_sol, c_eol, c_ld, c_fd, c_pd, c_fs;
    int e_sol, e_eol, e_ld, e_fd, e_pd, e_fs;
    int m_fc;
    bit m_lastf;
    bit gap_mode = 0;
    int n_act = 4, n_frame = 3, n_part = 2;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Output monitor, sampled on the falling edge.
    always @(negedge clk) begin
        logic [DW-1:0] d;
        int c;
        if (rst_n) begin
            if (pix_valid) begin
                if (q_dat.size() == 0) begin
                    check(0, "R3 unexpected pixel", int'(pix_data), -1);
                end else begin
                    d = q_dat.pop_front();
                    c = q_cyc.pop_front();
                    check(pix_data == d, "R2 pixel value", int'(pix_data), int'(d));
                    check(cyc == c, "R2 pixel latency", cyc, c);
                end
            end
            if (line_start)   c_sol++;
            if (line_end)     c_eol++;
            if (line_done)    c_ld++;
            if (frame_done)   c_fd++;
            if (partial_done) c_pd++;
            if (frame_start)  c_fs++;
        end
    end

    function automatic logic [DW-1:0] sc(input logic [7:0] b);
        return wide_mode ? {b, 2'b00} : {2'b00, b};
    endfunction

    task automatic put(input logic [DW-1:0] w);
        if (gap_mode) begin
            @(negedge clk);
            din = '1;
            din_en = 1'b0;
        end
        @(negedge clk);
        din = w;
        din_en = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            din_en = 1'b0;
        end
    endtask

    task automatic put_px(input logic [7:0] b, input bit expect_out);
        logic [DW-1:0] w;
        w = wide_mode ? {b, 2'b11} : {2'b00, b};
        put(w);
        if (expect_out) begin
            q_dat.push_back(w);
            q_cyc.push_back(cyc + 1);
        end
    endtask

    // R1: preamble FF 00 00 then status byte {1,F,V,H,xxxx}; low nibble is junk.
    task automatic code(input bit f, input bit v, input bit h);
        put(sc(8'hFF));
        put(sc(8'h00));
        put(sc(8'h00));
        put(sc({1'b1, f, v, h, 4'hA}));
    endtask

    task automatic line(input bit f, input bit v, input int npx, input int seed);
        code(f, v, 1'b0);
        if (v && !f && m_lastf) begin
            e_fs++;
            m_fc = 0;
        end
        m_lastf = f;
        for (int i = 0; i < npx; i++) begin
            put_px(8'h20 + 8'((i * 5 + seed) % 192), !v && i < n_act);
            if (!v && i == 0) e_sol++;
            if (!v && i == n_act - 1) e_eol++;
        end
        code(f, v, 1'b1);
        if (!v) begin
            e_ld++;
            m_fc++;
            if (m_fc == n_frame) e_fd++;
            if (n_part != 0 && m_fc == n_part) e_pd++;
        end
        // R1 near misses in blanking: wrong third word, and status bit 7 clear.
        put(sc(8'hFF)); put(sc(8'h00)); put(sc(8'h05)); put(sc(8'h80));
        put(sc(8'hFF)); put(sc(8'h00)); put(sc(8'h00)); put(sc(8'h60));
        put(sc(8'h10));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        din_en = 1'b0;
        din = '0;
        repeat (3) @(negedge clk);
        q_dat.delete();
        q_cyc.delete();
        c_sol = 0; c_eol = 0; c_ld = 0; c_fd = 0; c_pd = 0; c_fs = 0;
        e_sol = 0; e_eol = 0; e_ld = 0; e_fd = 0; e_pd = 0; e_fs = 0;
        m_fc = 0;
        m_lastf = 0;
        cfg_active_samples = PW'(n_act);
        cfg_frame_lines = LW'(n_frame);
        cfg_partial_lines = LW'(n_part);
        rst_n = 1'b1;
    endtask

    task automatic compare_counts(input string tag);
        check(c_sol == e_sol, {"R4 line_start count ", tag}, c_sol, e_sol);
        check(c_eol == e_eol, {"R4 line_end count ", tag}, c_eol, e_eol);
        check(c_ld == e_ld, {"R5 line_done count ", tag}, c_ld, e_ld);
        check(c_fs == e_fs, {"R7 frame_start count ", tag}, c_fs, e_fs);
        check(c_fd == e_fd, {"R8 frame_done count ", tag}, c_fd, e_fd);
        check(c_pd == e_pd, {"R9 partial_done count ", tag}, c_pd, e_pd);
        check(q_dat.size() == 0, {"R2 missing pixels ", tag}, q_dat.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R11: reset state.
        do_reset();
        @(negedge clk);
        check({pix_valid, line_start, line_end, field_id, vblank, frame_start,
               line_done, partial_done, frame_done, sync_lost} == 10'b0,
              "R11 outputs after reset",
              int'({pix_valid, line_start, line_end, field_id, vblank, frame_start,
                    line_done, partial_done, frame_done, sync_lost}), 0);

        // Sweep over sample width, line length and partial setting.
        for (int wm = 0; wm < 2; wm++) begin
            for (int n = 1; n <= 5; n++) begin
                wide_mode = wm[0];
                n_act = n;
                n_frame = 3;
                n_part = (n == 3) ? 0 : 2;   // R9 disabled case at n=3
                do_reset();
                // R11: words and an end code before any start code do nothing.
                put_px(8'h33, 0); put_px(8'h44, 0);
                code(1'b0, 1'b0, 1'b1);
                put(sc(8'h10));
                line(1'b1, 1'b1, n, 1);
                line(1'b0, 1'b1, n, 2);
                line(1'b0, 1'b0, n, 3);
                line(1'b0, 1'b0, n + 1, 4);   // R2 surplus samples dropped
                line(1'b0, 1'b0, n, 5);
                idle(2);
                check(field_id == 1'b0, "R6 field_id after active F=0", field_id, 0);
                check(vblank == 1'b0, "R6 vblank after active line", vblank, 0);
                line(1'b1, 1'b1, n, 6);
                idle(2);
                check(field_id == 1'b1, "R6 field_id after F=1 code", field_id, 1);
                check(vblank == 1'b1, "R6 vblank after V=1 code", vblank, 1);
                line(1'b1, 1'b0, n, 7);
                line(1'b1, 1'b0, n + 2, 8);
                line(1'b1, 1'b1, n, 9);
                line(1'b0, 1'b1, n, 10);
                line(1'b0, 1'b0, n, 11);
                idle(4);
                compare_counts($sformatf("sweep w%0d n%0d", wm, n));
            end
        end

        // R12: enable gaps carrying 0x3FF do not disturb detection or counting.
        wide_mode = 1'b1;
        n_act = 3; n_frame = 3; n_part = 2;
        do_reset();
        gap_mode = 1;
        line(1'b1, 1'b1, 3, 1);
        line(1'b0, 1'b1, 3, 2);
        line(1'b0, 1'b0, 3, 3);
        line(1'b0, 1'b0, 3, 4);
        line(1'b0, 1'b0, 4, 5);
        gap_mode = 0;
        idle(4);
        compare_counts("R12 gaps");

        // R10: short line, hunting, recovery.
        wide_mode = 1'b0;
        n_act = 4; n_frame = 3; n_part = 2;
        do_reset();
        line(1'b0, 1'b0, 4, 1);
        code(1'b0, 1'b0, 1'b0);
        m_lastf = 0;
        put_px(8'h50, 1);
        put_px(8'h51, 1);
        e_sol++;
        // Preamble words fill the remaining pixel slots of the short line.
        put(sc(8'hFF)); q_dat.push_back(10'h0FF); q_cyc.push_back(cyc + 1);
        put(sc(8'h00)); q_dat.push_back(10'h000); q_cyc.push_back(cyc + 1);
        e_eol++;
        put(sc(8'h00));
        put(sc({1'b1, 1'b0, 1'b0, 1'b1, 4'h3}));
        idle(1);
        check(sync_lost == 1'b1, "R10 sync_lost one clock after short EAV", sync_lost, 1);
        check(line_done == 1'b0, "R10 no line_done on short line", line_done, 0);
        put_px(8'h61, 0); put_px(8'h62, 0); put_px(8'h63, 0);
        code(1'b0, 1'b0, 1'b1);
        idle(2);
        check(sync_lost == 1'b1, "R10 sync_lost held while hunting", sync_lost, 1);
        compare_counts("R10 after loss");
        line(1'b0, 1'b0, 4, 7);
        idle(2);
        check(sync_lost == 1'b0, "R10 sync_lost cleared by SAV", sync_lost, 0);
        compare_counts("R10 recovery");

        idle(2);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule